// File: doc/BRIEF.md
# Processor exception entry controller

This block decides, one cycle at a time, whether a small 32-bit processor enters an exception handler and where it goes. A synchronous exception arrives as a valid strobe with a cause code. An external interrupt arrives as a level request. The block also reads the current program counter, the three interrupt-enable bits (global, saved-for-exception, saved-for-debug), the ordinary and debug vector bases, and a remap control bit.

One clock after an accepted request, the block pulses a redirect strobe. With the strobe it presents the handler address, a register-file write that saves the return PC, and the interrupt-enable value the core must load. Each handler slot is 32 bytes wide, so the target address is the selected base plus the cause number shifted left by five.

Debug causes (breakpoint, watchpoint) save into their own return register and their own saved-enable bit. They always use the debug base. Every other cause uses the exception-address register and the exception saved-enable bit. These causes go to the ordinary base, or to the debug base when remap is set. A code outside the defined set produces a one-cycle error pulse and no redirect.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The redirect PC equals the selected base plus the cause code times 32. Cause codes are: 0 reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call.
- R2: For a non-debug cause (0, 2, 4, 5, 6, 7), the current PC is written to register index 30.
- R3: For a non-debug cause, the next exception saved-enable bit equals the global enable at entry, and the debug saved-enable bit is passed through unchanged.
- R4: A non-debug cause uses the ordinary base when remap is 0 and the debug base when remap is 1.
- R5: For a debug cause (1 or 3), the current PC is written to register index 31. The next debug saved-enable bit equals the global enable, the exception saved-enable bit is passed through, and the debug base is used regardless of remap.
- R6: An interrupt request with no synchronous exception is taken as cause 6 only while the global enable is 1. Otherwise no redirect occurs.
- R7: Every entry drives the next global enable to 0.
- R8: When a synchronous exception and an interrupt request arrive in the same cycle, the synchronous exception is taken and the interrupt is not.
- R9: A synchronous code of 8 or above pulses the error output for one cycle, with no redirect and no register write.
- R10: While reset is asserted, the redirect strobe, the register write enable and the error output are all 0.
- R11: All outputs appear exactly one cycle after the request. A cycle with no request produces no strobe and no error in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception request this cycle |
| exc_cause | input | 4 | Cause code of the synchronous request |
| irq_req | input | 1 | External interrupt request (level) |
| cur_pc | input | 32 | PC of the instruction taking the exception |
| ie_gie | input | 1 | Global interrupt-enable bit |
| ie_eie | input | 1 | Exception saved-enable bit |
| ie_bie | input | 1 | Debug saved-enable bit |
| eba | input | 32 | Ordinary exception base |
| deba | input | 32 | Debug exception base |
| remap | input | 1 | Send non-debug causes to the debug base |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler address |
| rf_we | output | 1 | Register-file write enable for the return PC |
| rf_idx | output | 5 | Register index written (30 or 31) |
| rf_wdata | output | 32 | Saved return PC |
| ie_next_gie | output | 1 | Next global enable |
| ie_next_eie | output | 1 | Next exception saved-enable |
| ie_next_bie | output | 1 | Next debug saved-enable |
| cause_err | output | 1 | Unknown-cause error pulse |

## Verification
On every cycle, the assertions check several properties:
- a masked interrupt never redirects;
- an unknown code always raises the error without a redirect;
- a defined synchronous request always redirects and saves the PC, even with an interrupt pending;
- a breakpoint lands one slot above the debug base;
- every entry clears the global enable;
- an idle cycle stays quiet.

Only the bench's sweep shows the remaining behaviour. It runs every code against every enable pattern, remap setting and interrupt level. This is what shows that each cause reaches the correct base and slot, that the saved-enable bits go to the right side, and that the return index depends on the debug class.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int RF_AW      = 5,
  parameter int EA_IDX     = 30,
  parameter int BA_IDX     = 31,
  parameter int SLOT_SHIFT = 5,
  parameter int NUM_CAUSES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               irq_req,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               ie_gie,
  input  logic               ie_eie,
  input  logic               ie_bie,
  input  logic [XLEN-1:0]    eba,
  input  logic [XLEN-1:0]    deba,
  input  logic               remap,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_idx,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               ie_next_gie,
  output logic               ie_next_eie,
  output logic               ie_next_bie,
  output logic               cause_err
);

  localparam logic [CAUSE_W-1:0] C_BRK   = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_WATCH = CAUSE_W'(3);
  localparam logic [CAUSE_W-1:0] C_IRQ   = CAUSE_W'(6);

  logic               known, take_irq, enter, is_dbg;
  logic [CAUSE_W-1:0] sel_cause;
  logic [XLEN-1:0]    base, target;

  assign known     = int'(exc_cause) < NUM_CAUSES;
  assign take_irq  = irq_req && ie_gie && !exc_valid;
  assign enter     = (exc_valid && known) || take_irq;
  assign sel_cause = exc_valid ? exc_cause : C_IRQ;
  assign is_dbg    = exc_valid && (exc_cause == C_BRK || exc_cause == C_WATCH);
  assign base      = (is_dbg || remap) ? deba : eba;
  assign target    = base + (XLEN'(sel_cause) << SLOT_SHIFT);
  assign rf_we     = redir_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      cause_err   <= 1'b0;
      redir_pc    <= '0;
      rf_idx      <= '0;
      rf_wdata    <= '0;
      ie_next_gie <= 1'b0;
      ie_next_eie <= 1'b0;
      ie_next_bie <= 1'b0;
    end else begin
      redir_valid <= enter;
      cause_err   <= exc_valid && !known;
      if (enter) begin
        redir_pc    <= target;
        rf_wdata    <= cur_pc;
        rf_idx      <= is_dbg ? RF_AW'(BA_IDX) : RF_AW'(EA_IDX);
        ie_next_gie <= 1'b0;
        ie_next_eie <= is_dbg ? ie_eie : ie_gie;
        ie_next_bie <= is_dbg ? ie_gie : ie_bie;
      end
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !exc_valid && !ie_gie) |=> !redir_valid); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && int'(exc_cause) >= NUM_CAUSES) |=> (cause_err && !redir_valid && !rf_we)); // R9

  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && irq_req && int'(exc_cause) < NUM_CAUSES) |=> (redir_valid && rf_wdata == $past(cur_pc))); // R8

  AST_BRK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == C_BRK) |=> (redir_pc == $past(deba) + (XLEN'(1) << SLOT_SHIFT))); // R5

  AST_GIE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !ie_next_gie); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !irq_req) |=> (!redir_valid && !cause_err)); // R11

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_cause = '0;
  logic        irq_req = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        ie_gie = 1'b0, ie_eie = 1'b0, ie_bie = 1'b0;
  logic [31:0] eba = '0, deba = '0;
  logic        remap = 1'b0;
  logic        redir_valid, rf_we, ie_next_gie, ie_next_eie, ie_next_bie, cause_err;
  logic [31:0] redir_pc, rf_wdata;
  logic [4:0]  rf_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .irq_req(irq_req), .cur_pc(cur_pc), .ie_gie(ie_gie), .ie_eie(ie_eie),
    .ie_bie(ie_bie), .eba(eba), .deba(deba), .remap(remap),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .ie_next_gie(ie_next_gie),
    .ie_next_eie(ie_next_eie), .ie_next_bie(ie_next_bie), .cause_err(cause_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(input bit ev, input int cause, input bit irq, input bit g,
                         input bit e, input bit b, input bit rm, input int n);
    bit          x_valid, x_err, dbg;
    int          c;
    logic [31:0] x_base, x_pc;
    @(negedge clk);
    exc_valid = ev; exc_cause = 4'(cause); irq_req = irq;
    ie_gie = g; ie_eie = e; ie_bie = b; remap = rm;
    cur_pc = 32'h1000_0000 + 32'(n) * 4;
    eba    = 32'h0000_4000 + (32'(n % 7) << 12);
    deba   = 32'h8000_0000 + (32'(n % 5) << 12);
    x_err = 0; x_valid = 0; dbg = 0; c = 6;
    if (ev) begin
      if (cause < 8) begin
        x_valid = 1; c = cause; dbg = (cause == 1 || cause == 3);
      end else x_err = 1;
    end else if (irq && g) x_valid = 1;
    x_base = (dbg || rm) ? deba : eba;
    x_pc   = x_base + 32'(c) * 32;
    @(negedge clk);
    chk(redir_valid == x_valid, ev ? (irq ? "R8" : "R11") : "R6", 32'(redir_valid), 32'(x_valid));
    chk(rf_we == x_valid, ev ? "R9" : "R6", 32'(rf_we), 32'(x_valid));
    chk(cause_err == x_err, "R9", 32'(cause_err), 32'(x_err));
    if (x_valid) begin
      chk(redir_pc == x_pc, dbg ? "R5" : (rm ? "R4" : "R1"), redir_pc, x_pc);
      chk(rf_idx == (dbg ? 5'd31 : 5'd30), dbg ? "R5" : "R2", 32'(rf_idx), dbg ? 32'd31 : 32'd30);
      chk(rf_wdata == cur_pc, dbg ? "R5" : "R2", rf_wdata, cur_pc);
      chk(ie_next_gie == 1'b0, "R7", 32'(ie_next_gie), 32'd0);
      chk(ie_next_eie == (dbg ? e : g), dbg ? "R5" : "R3", 32'(ie_next_eie), 32'(dbg ? e : g));
      chk(ie_next_bie == (dbg ? g : b), dbg ? "R5" : "R3", 32'(ie_next_bie), 32'(dbg ? g : b));
    end
    exc_valid = 0; irq_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(redir_valid == 0 && rf_we == 0 && cause_err == 0, "R10",
        {29'd0, redir_valid, rf_we, cause_err}, 32'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 1024; n++) begin
      run_one(n[0], (n >> 1) & 15, n[5], n[6], n[7], n[8], n[9], n);
    end
    @(negedge clk);
    chk(redir_valid == 0 && cause_err == 0, "R11", {30'd0, redir_valid, cause_err}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule